// File: doc/BRIEF.md
# Rate-1/2 Convolutional Encoder with Rate-2/3 Puncturing

This block encodes a serial bit stream with a rate-1/2 binary convolutional code of four taps (an input bit plus three state bits, eight states). Each accepted data bit produces two code bits, one per generator. The generators are 1111 and 1101 over {input, s1, s2, s3}. When the last bit of a frame is accepted, the block encodes three zero tail bits on its own. This returns the state to all zeros. Input is held off while the tail runs.

A mode input chooses between plain rate-1/2 output and a punctured rate-2/3 output. In punctured mode the four code bits of each pair of encoder steps are reduced to three by dropping the first code bit of the second step. The three bits leave as one group. The mode is sampled only on the first bit of a frame. Each output beat carries up to three bits and a keep mask that marks which of them are valid.

Top module: `conv_enc_punct`

## Requirements
- R1: After reset, out_vld, busy and out_keep are 0 and the encoder state is 000, so the first frame starts from the zero state.
- R2: For input u and state {s1,s2,s3}, code bit A = u^s1^s2^s3 and code bit B = u^s1^s3, and the next state is {u,s1,s2}. In rate-1/2 mode a step emits out_bits[0]=A, out_bits[1]=B, out_bits[2]=0, with out_keep=3'b011.
- R3: Accepting a bit with in_last set makes busy high for exactly the next three cycles. During those cycles three zero bits are encoded and the state returns to 000. A frame holding only a 1 yields the bit stream 11 11 10 11.
- R4: An in_vld beat presented while busy is high is not accepted and has no effect on the output stream.
- R5: The frame 1011 in rate-1/2 mode yields 11 11 01 11 01 01 11, tail included.
- R6: In punctured mode the first step of a pair emits nothing. The second step emits out_bits = {B2, B1, A1} (A1 and B1 from the first step, B2 from the second) with out_keep=3'b111, so A2 is dropped.
- R7: In punctured mode, if the final tail step of a frame falls on the first step of a pair, it is emitted alone with out_keep=3'b011, and the pairing restarts for the next frame.
- R8: The mode (punct_en=1 for punctured) is latched only on an accepted beat with in_sof set. Changes to punct_en at any other time do not affect the frame in progress.
- R9: The output of an encoder step appears on the cycle after the step (one register). While out_vld is low, out_keep is 000. While out_vld is high, out_keep is 011 or 111.
- R10: A cycle with in_vld low and busy low changes neither the state nor the output (out_vld stays low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| punct_en | input | 1 | Mode request, sampled with in_sof: 1 = rate 2/3 |
| in_vld | input | 1 | Input bit strobe |
| in_sof | input | 1 | Marks the first bit of a frame |
| in_last | input | 1 | Marks the last data bit of a frame |
| in_bit | input | 1 | Data bit |
| busy | output | 1 | High while tail bits are encoded; input not accepted |
| out_vld | output | 1 | Output group valid |
| out_bits | output | 3 | Code bits, bit 0 sent first |
| out_keep | output | 3 | Per-bit valid mask for out_bits |

## Verification
On every cycle, the assertions check the following:
- busy rises after a last bit is accepted, and the state is zero when busy falls.
- The keep mask is legal and matches out_vld.
- A frame started in rate-1/2 mode gives a two-bit symbol on the next cycle.
- Idle cycles leave the state and output unchanged.

The actual code bit values, the tail contents, the puncturing pattern and its handling of odd remainders, mode latching, and ignoring input while busy are shown only by the bench. Its scenarios compare every cycle against a behavioural model and check the collected bit streams against the known sequences.

// File: rtl/conv_enc_pkg.sv
package conv_enc_pkg;
    typedef enum logic [2:0] {
        KEEP_NONE   = 3'b000,
        KEEP_PAIR   = 3'b011,
        KEEP_TRIPLE = 3'b111
    } keep_e;
endpackage

// File: rtl/conv_core.sv
module conv_core #(
    parameter int          TAPS = 4,
    parameter logic [3:0]  GEN_A = 4'b1111,
    parameter logic [3:0]  GEN_B = 4'b1101,
    localparam int         SW = TAPS - 1
) (
    input  logic [SW-1:0] state,
    input  logic          u,
    output logic [SW-1:0] state_nxt,
    output logic [1:0]    code
);
    logic [TAPS-1:0] window;

    always_comb begin
        window    = {u, state};
        code[0]   = ^(window & GEN_A[TAPS-1:0]);
        code[1]   = ^(window & GEN_B[TAPS-1:0]);
        state_nxt = window[TAPS-1:1];
    end
endmodule

// File: rtl/punct_pack.sv
module punct_pack
    import conv_enc_pkg::*;
(
    input  logic       step,
    input  logic       mode,
    input  logic       phase,
    input  logic [1:0] held,
    input  logic [1:0] code,
    input  logic       final_step,
    output logic       emit,
    output logic [2:0] bits,
    output logic [2:0] keep,
    output logic       phase_nxt,
    output logic [1:0] held_nxt
);
    always_comb begin
        emit      = 1'b0;
        bits      = 3'b000;
        keep      = KEEP_NONE;
        phase_nxt = phase;
        held_nxt  = held;
        if (step) begin
            if (!mode) begin
                emit = 1'b1;
                bits = {1'b0, code};
                keep = KEEP_PAIR;
            end else if (!phase) begin
                if (final_step) begin
                    emit = 1'b1;
                    bits = {1'b0, code};
                    keep = KEEP_PAIR;
                end else begin
                    held_nxt  = code;
                    phase_nxt = 1'b1;
                end
            end else begin
                emit      = 1'b1;
                bits      = {code[1], held};
                keep      = KEEP_TRIPLE;
                phase_nxt = 1'b0;
            end
        end
    end
endmodule

// File: rtl/conv_enc_punct.sv
module conv_enc_punct #(
    parameter int TAPS = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       punct_en,
    input  logic       in_vld,
    input  logic       in_sof,
    input  logic       in_last,
    input  logic       in_bit,
    output logic       busy,
    output logic       out_vld,
    output logic [2:0] out_bits,
    output logic [2:0] out_keep
);
    localparam int SW   = TAPS - 1;
    localparam int TAIL = SW;
    localparam int TW   = $clog2(TAIL + 1);

    typedef struct packed {
        logic [SW-1:0] state;
        logic [TW-1:0] tail;
        logic          mode;
        logic          phase;
        logic [1:0]    held;
        logic          vld;
        logic [2:0]    bits;
        logic [2:0]    keep;
    } regs_t;

    regs_t r_q, r_d;

    logic          accept, step, final_step, sof_hit, mode_eff, phase_eff;
    logic          u, emit, phase_nxt;
    logic [SW-1:0] state_nxt;
    logic [1:0]    code, held_nxt;
    logic [2:0]    pk_bits, pk_keep;
    logic [SW-1:0] enc_state;

    assign busy      = (r_q.tail != '0);
    assign accept    = in_vld && !busy;
    assign step      = accept || busy;
    assign final_step = (r_q.tail == TW'(1));
    assign sof_hit   = accept && in_sof;
    assign mode_eff  = sof_hit ? punct_en : r_q.mode;
    assign phase_eff = sof_hit ? 1'b0 : r_q.phase;
    assign u         = accept ? in_bit : 1'b0;
    assign enc_state = r_q.state;

    conv_core #(.TAPS(TAPS)) core_i (
        .state     (r_q.state),
        .u         (u),
        .state_nxt (state_nxt),
        .code      (code)
    );

    punct_pack pack_i (
        .step       (step),
        .mode       (mode_eff),
        .phase      (phase_eff),
        .held       (r_q.held),
        .code       (code),
        .final_step (final_step),
        .emit       (emit),
        .bits       (pk_bits),
        .keep       (pk_keep),
        .phase_nxt  (phase_nxt),
        .held_nxt   (held_nxt)
    );

    always_comb begin
        r_d       = r_q;
        r_d.mode  = mode_eff;
        r_d.phase = phase_nxt;
        r_d.held  = held_nxt;
        r_d.vld   = emit;
        r_d.bits  = pk_bits;
        r_d.keep  = pk_keep;
        if (step) begin
            r_d.state = state_nxt;
        end
        if (accept && in_last) begin
            r_d.tail = TW'(TAIL);
        end else if (busy) begin
            r_d.tail = r_q.tail - TW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign out_vld  = r_q.vld;
    assign out_bits = r_q.bits;
    assign out_keep = r_q.keep;
endmodule

// File: rtl/conv_enc_punct_chk.sv
module conv_enc_punct_chk #(
    parameter int SW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          punct_en,
    input logic          in_vld,
    input logic          in_sof,
    input logic          in_last,
    input logic          busy,
    input logic          out_vld,
    input logic [2:0]    out_keep,
    input logic [SW-1:0] state
);
    assert_last_sets_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && !busy && in_last) |=> busy);

    assert_flush_to_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (state == '0));

    assert_keep_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> (out_keep == 3'b011 || out_keep == 3'b111));

    assert_keep_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !out_vld |-> (out_keep == 3'b000));

    assert_plain_mode_symbol_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && !busy && in_sof && !punct_en) |=> (out_vld && out_keep == 3'b011));

    assert_idle_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_vld && !busy) |=> (!out_vld && $stable(state)));
endmodule

bind conv_enc_punct conv_enc_punct_chk #(.SW(TAPS - 1)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .punct_en (punct_en),
    .in_vld   (in_vld),
    .in_sof   (in_sof),
    .in_last  (in_last),
    .busy     (busy),
    .out_vld  (out_vld),
    .out_keep (out_keep),
    .state    (enc_state)
);

// File: tb/conv_enc_punct_tb.sv
module conv_enc_punct_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic punct_en = 1'b0, in_vld = 1'b0, in_sof = 1'b0, in_last = 1'b0, in_bit = 1'b0;
    logic busy, out_vld;
    logic [2:0] out_bits, out_keep;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    conv_enc_punct dut_i (
        .clk(clk), .rst_n(rst_n), .punct_en(punct_en), .in_vld(in_vld),
        .in_sof(in_sof), .in_last(in_last), .in_bit(in_bit), .busy(busy),
        .out_vld(out_vld), .out_bits(out_bits), .out_keep(out_keep)
    );

    // Behavioural reference model
    int  m_s1, m_s2, m_s3, m_tail, m_phase, m_h1, m_h2, m_mode;
    int  e_vld, e_bits, e_keep;

    always @(posedge clk) begin
        int uu, a, b, acc, lastt;
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_s3 = 0; m_tail = 0; m_phase = 0;
            m_h1 = 0; m_h2 = 0; m_mode = 0; e_vld = 0; e_bits = 0; e_keep = 0;
        end else begin
            e_vld = 0; e_bits = 0; e_keep = 0;
            acc = (in_vld && m_tail == 0) ? 1 : 0;
            lastt = (m_tail == 1) ? 1 : 0;
            if (acc == 1 || m_tail > 0) begin
                uu = (acc == 1) ? int'(in_bit) : 0;
                if (acc == 1 && in_sof) begin m_mode = int'(punct_en); m_phase = 0; end
                a = (uu + m_s1 + m_s2 + m_s3) % 2;
                b = (uu + m_s1 + m_s3) % 2;
                m_s3 = m_s2; m_s2 = m_s1; m_s1 = uu;
                if (m_mode == 0) begin
                    e_vld = 1; e_bits = b * 2 + a; e_keep = 3;
                end else if (m_phase == 0) begin
                    if (lastt == 1) begin e_vld = 1; e_bits = b * 2 + a; e_keep = 3; end
                    else begin m_h1 = a; m_h2 = b; m_phase = 1; end
                end else begin
                    e_vld = 1; e_bits = b * 4 + m_h2 * 2 + m_h1; e_keep = 7; m_phase = 0;
                end
                if (acc == 1 && in_last) m_tail = 3;
                else if (m_tail > 0) m_tail = m_tail - 1;
            end
        end
    end

    bit stream[$];

    always @(negedge clk) begin
        cycles++;
        if (rst_n && !done) begin
            checks++;
            if (int'(out_vld) != e_vld || int'(out_keep) != e_keep ||
                (e_vld == 1 && int'(out_bits) != e_bits) || int'(busy) != (m_tail > 0 ? 1 : 0)) begin
                errors++;
                $display("FAIL R2/R9 cycle %0d: vld %0d bits %0d keep %0d busy %0d, expected vld %0d bits %0d keep %0d busy %0d",
                         cycles, out_vld, out_bits, out_keep, busy, e_vld, e_bits, e_keep, m_tail > 0);
            end
            if (out_vld) begin
                for (int i = 0; i < 3; i++) if (out_keep[i]) stream.push_back(out_bits[i]);
            end
        end
    end

    task automatic check_stream(string tag, string exp);
        string got = "";
        foreach (stream[i]) got = {got, stream[i] ? "1" : "0"};
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s stream: got %s expected %s", tag, got, exp);
        end
        stream.delete();
    endtask

    task automatic send_frame(string data, bit mode, bit flip_mode, bit junk_busy, bit gaps);
        for (int i = 0; i < data.len(); i++) begin
            @(negedge clk);
            while (busy) @(negedge clk);
            in_vld   = 1'b1;
            in_sof   = (i == 0);
            in_last  = (i == data.len() - 1);
            in_bit   = (data[i] == "1");
            punct_en = (i == 0) ? mode : (flip_mode ? ~mode : mode);
            if (gaps) begin @(negedge clk); in_vld = 1'b0; end
        end
        @(negedge clk);
        in_sof = 1'b0; in_last = 1'b0;
        if (junk_busy) begin
            // R4: offer bits during the three busy cycles
            in_vld = 1'b1; in_bit = 1'b1;
            repeat (2) @(negedge clk);
        end
        in_vld = 1'b0; in_bit = 1'b0;
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (out_vld !== 1'b0 || busy !== 1'b0 || out_keep !== 3'b000) begin
            errors++;
            $display("FAIL R1 reset: vld %0b busy %0b keep %0b expected 0 0 000", out_vld, busy, out_keep);
        end
        send_frame("1", 1'b0, 1'b0, 1'b0, 1'b0);
        check_stream("R3 impulse", "11111011");
        send_frame("1011", 1'b0, 1'b0, 1'b0, 1'b0);
        check_stream("R5 frame 1011", "11110111010111");
        send_frame("1", 1'b0, 1'b0, 1'b1, 1'b0);
        check_stream("R4 busy input ignored", "11111011");
        send_frame("1011", 1'b0, 1'b0, 1'b0, 1'b1);
        check_stream("R10 stalled frame", "11110111010111");
        send_frame("1011", 1'b1, 1'b0, 1'b0, 1'b0);
        check_stream("R7 punct odd remainder", "11101101111");
        send_frame("101", 1'b1, 1'b0, 1'b0, 1'b0);
        check_stream("R6 punct even", "111010101");
        send_frame("1011", 1'b0, 1'b1, 1'b0, 1'b0);
        check_stream("R8 mode held plain", "11110111010111");
        send_frame("101", 1'b1, 1'b1, 1'b0, 1'b1);
        check_stream("R8 mode held punct", "111010101");
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wait (cycles > 20000);
        checks++;
        errors++;
        $display("FAIL watchdog: cycles %0d expected under 20000", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule